// File: doc/BRIEF.md
# Bit Timing Generator with Line Coder

This block produces the serial bit timing for a transmit path and formats the outgoing data stream for the modulator. A free-running prescaler divides the reference clock into half-tick strobes. A bit timer counts those strobes against an 8-bit rate setting to mark bit boundaries and bit midpoints. A formatter turns the serial input into a modulation output in one of three formats: a direct pass-through, a copy resampled once per bit, or a two-chip Manchester code.

The host drives `restart_i` whenever it writes the block's configuration and whenever it starts a new transmission. A restart captures the format and rate inputs, clears every phase counter, and begins a fresh bit period, so the first boundary falls one full bit period later. The host uses the one-cycle `bit_stb_o` pulse to present the next data bit. With `HALF_DIV` = 4 and a 50 MHz reference, a rate setting of 0 gives 8 clocks per bit.

Top module: `bit_timing_coder`

## Requirements
- R1: After reset, `bit_stb_o` is low and the active format is pass-through, so `mod_o` equals `data_i`.
- R2: Format code 2'b00 selects pass-through, 2'b01 selects resampled, 2'b10 selects Manchester, and 2'b11 behaves as resampled.
- R3: One bit period lasts 2*HALF_DIV*(rate+1) clock cycles. `bit_stb_o` is a single-cycle pulse that rises once per period.
- R4: After the clock edge that samples `restart_i` high, the first `bit_stb_o` is seen exactly one bit period (in clock edges) later.
- R5: In pass-through format, `mod_o` follows `data_i` within the same cycle, with no resampling.
- R6: In resampled format, `data_i` is captured at the restart edge and at each edge where `bit_stb_o` rises, and `mod_o` holds that value for the whole bit period.
- R7: In Manchester format, a 1 is sent high for the first half-period and low for the second, and a 0 is sent low then high. The change of chip happens half a bit period after the bit starts.
- R8: After a restart, the Manchester code begins with the first-half chip.
- R9: Rate setting 0 gives the shortest period of 2*HALF_DIV cycles, and rate setting 255 gives 512*HALF_DIV cycles.
- R10: A restart in the middle of a period cancels the pending strobe. No `bit_stb_o` occurs until one full period after the new restart.
- R11: `mode_i` and `rate_i` take effect only on a cycle where `restart_i` is high. Changes to them at other times do not affect the period or the format.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| restart_i | input | 1 | Restart pulse from a configuration write or transmission start |
| mode_i | input | 2 | Output format code, captured on restart |
| rate_i | input | RATE_W | Bit rate divider setting, captured on restart |
| data_i | input | 1 | Serial transmit data |
| bit_stb_o | output | 1 | One-cycle bit clock strobe for the host |
| mod_o | output | 1 | Formatted modulation output |

## Verification
The bench measures the distance from a restart to the first strobe at the fastest rate, at the slowest rate and at a middle rate. A design that is off by one in the divider would show a period short or long by one half-tick or one clock.

It restarts in the middle of a period and checks that no stale strobe leaks out; a design that failed to clear the counters would fire early. It changes the format and rate without a restart and checks that both are ignored, which catches a design that reads the live inputs.

In Manchester format, the bench samples on both sides of the midpoint for both bit values. This catches inverted chip polarity and a phase that starts in the second half. In resampled format, it changes the data in mid-bit and checks that `mod_o` does not follow until the boundary.

// File: rtl/btc_pkg.sv
package btc_pkg;
  typedef enum logic [1:0] {
    FMT_ASYNC    = 2'b00,
    FMT_SYNC     = 2'b01,
    FMT_MANCH    = 2'b10,
    FMT_SYNC_ALT = 2'b11
  } fmt_e;
endpackage

// File: rtl/btc_prescaler.sv
module btc_prescaler #(
  parameter int HALF_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic half_tick_o
);
  localparam int PW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  generate
    if (HALF_DIV == 1) begin : g_bypass
      assign half_tick_o = 1'b1;
    end else begin : g_count
      logic [PW-1:0] pre_cnt;
      assign half_tick_o = (pre_cnt == PW'(HALF_DIV - 1));

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)          pre_cnt <= '0;
        else if (restart_i)   pre_cnt <= '0;
        else if (half_tick_o) pre_cnt <= '0;
        else                  pre_cnt <= pre_cnt + 1'b1;
      end

      // two half-ticks are never back to back when dividing
      assert_tick_gap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        half_tick_o |=> !half_tick_o);
    end
  endgenerate
endmodule

// File: rtl/btc_bit_timer.sv
module btc_bit_timer #(
  parameter int RATE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic              half_tick_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              edge_o,
  output logic              mid_o,
  output logic              bit_stb_o
);
  localparam int HW = RATE_W + 1;

  logic [HW-1:0] hcnt;
  logic [HW-1:0] last_half;
  logic [HW-1:0] mid_half;
  logic          stb_q;

  assign last_half = {rate_i, 1'b1};   // 2*(rate+1)-1
  assign mid_half  = {1'b0, rate_i};   // (rate+1)-1
  assign edge_o    = half_tick_i && (hcnt == last_half);
  assign mid_o     = half_tick_i && (hcnt == mid_half);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          hcnt <= '0;
    else if (restart_i)   hcnt <= '0;
    else if (half_tick_i) hcnt <= (hcnt == last_half) ? '0 : hcnt + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        stb_q <= 1'b0;
    else if (restart_i) stb_q <= 1'b0;
    else                stb_q <= edge_o;
  end

  assign bit_stb_o = stb_q;

  assert_stb_on_tick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_stb_o |-> $past(half_tick_i));
  assert_stb_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_stb_o |=> !bit_stb_o);
  assert_hcnt_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hcnt <= last_half);
  assert_restart_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (!bit_stb_o && hcnt == '0));
endmodule

// File: rtl/btc_formatter.sv
module btc_formatter
  import btc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic edge_i,
  input  logic mid_i,
  input  fmt_e fmt_i,
  input  logic data_i,
  output logic mod_o
);
  logic data_q;
  logic half_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= 1'b0;
      half_q <= 1'b0;
    end else if (restart_i || edge_i) begin
      data_q <= data_i;
      half_q <= 1'b0;
    end else if (mid_i) begin
      half_q <= 1'b1;
    end
  end

  always_comb begin
    unique case (fmt_i)
      FMT_ASYNC: mod_o = data_i;
      FMT_MANCH: mod_o = data_q ^ half_q;  // 1 -> high,low ; 0 -> low,high
      default:   mod_o = data_q;
    endcase
  end

  assert_sync_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!restart_i && !edge_i) |=> $stable(data_q));
  assert_manch_mid_flip_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fmt_i == FMT_MANCH && mid_i && !restart_i) |=> (mod_o != $past(mod_o)));
  assert_first_half_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !half_q);
endmodule

// File: rtl/bit_timing_coder.sv
module bit_timing_coder
  import btc_pkg::*;
#(
  parameter int RATE_W   = 8,
  parameter int HALF_DIV = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic [1:0]        mode_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              data_i,
  output logic              bit_stb_o,
  output logic              mod_o
);
  fmt_e              fmt_q;
  logic [RATE_W-1:0] rate_q;
  logic              half_tick;
  logic              bit_edge;
  logic              bit_mid;

  // settings are taken only with a restart
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fmt_q  <= FMT_ASYNC;
      rate_q <= '0;
    end else if (restart_i) begin
      fmt_q  <= fmt_e'(mode_i);
      rate_q <= rate_i;
    end
  end

  btc_prescaler #(.HALF_DIV(HALF_DIV)) u_pre (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .restart_i   (restart_i),
    .half_tick_o (half_tick)
  );

  btc_bit_timer #(.RATE_W(RATE_W)) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .restart_i   (restart_i),
    .half_tick_i (half_tick),
    .rate_i      (rate_q),
    .edge_o      (bit_edge),
    .mid_o       (bit_mid),
    .bit_stb_o   (bit_stb_o)
  );

  btc_formatter u_fmt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart_i),
    .edge_i    (bit_edge),
    .mid_i     (bit_mid),
    .fmt_i     (fmt_q),
    .data_i    (data_i),
    .mod_o     (mod_o)
  );

  assert_cfg_latched_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(restart_i) |-> ($stable(rate_q) && $stable(fmt_q)));
endmodule

// File: tb/bit_timing_coder_tb_top.sv
`timescale 1ns/1ps
module bit_timing_coder_tb_top;
  localparam int RATE_W   = 8;
  localparam int HALF_DIV = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             restart = 1'b0;
  logic [1:0]       mode = 2'b00;
  logic [RATE_W-1:0] rate = '0;
  logic             data = 1'b0;
  logic             bit_stb;
  logic             mod_out;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  bit_timing_coder #(.RATE_W(RATE_W), .HALF_DIV(HALF_DIV)) dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .restart_i (restart),
    .mode_i    (mode),
    .rate_i    (rate),
    .data_i    (data),
    .bit_stb_o (bit_stb),
    .mod_o     (mod_out)
  );

  function automatic int period(input int r);
    return 2 * HALF_DIV * (r + 1);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // ends at the negedge after the restart edge (position 0)
  task automatic do_restart(input logic [1:0] m, input int r, input logic d);
    @(negedge clk);
    restart = 1'b1; mode = m; rate = RATE_W'(r); data = d;
    @(posedge clk);
    @(negedge clk);
    restart = 1'b0;
  endtask

  task automatic step(input int k);
    for (int i = 0; i < k; i++) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  // edges until strobe seen, limit-bounded
  task automatic edges_to_stb(input int lim, output int n);
    n = 0;
    for (int i = 1; i <= lim; i++) begin
      @(posedge clk); @(negedge clk);
      if (bit_stb) begin n = i; break; end
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(bit_stb == 1'b0, "R1 strobe low", int'(bit_stb), 0);
    data = 1'b1; #1;
    chk(mod_out == 1'b1, "R1 passthrough default", int'(mod_out), 1);
    data = 1'b0; #1;
    chk(mod_out == 1'b0, "R1 passthrough default", int'(mod_out), 0);
  endtask

  task automatic t_period(input int r, input string tag);
    int n;
    do_restart(2'b01, r, 1'b0);
    edges_to_stb(period(r) + 4, n);
    chk(n == period(r), tag, n, period(r));
    step(1);
    chk(bit_stb == 1'b0, "R3 single pulse", int'(bit_stb), 0);
    edges_to_stb(period(r) + 4, n);
    chk(n == period(r) - 1, "R3 steady period", n + 1, period(r));
  endtask

  task automatic t_async;
    do_restart(2'b00, 2, 1'b0);
    for (int i = 0; i < 4; i++) begin
      data = i[0]; #1;
      chk(mod_out == i[0], "R5 async follow", int'(mod_out), int'(i[0]));
      step(1);
    end
  endtask

  task automatic t_sync(input logic [1:0] m, input string tag);
    int p;
    p = period(1);
    do_restart(m, 1, 1'b1);
    data = 1'b0;
    chk(mod_out == 1'b1, tag, int'(mod_out), 1);
    step(p - 1);
    chk(mod_out == 1'b1, "R6 hold to end of bit", int'(mod_out), 1);
    step(1);
    chk(mod_out == 1'b0 && bit_stb, "R6 new bit at strobe", int'(mod_out), 0);
  endtask

  task automatic t_manch;
    int p;
    p = period(2);
    do_restart(2'b10, 2, 1'b1);
    chk(mod_out == 1'b1, "R8 first chip of one", int'(mod_out), 1);
    data = 1'b0;
    step(p/2 - 1);
    chk(mod_out == 1'b1, "R7 one first half", int'(mod_out), 1);
    step(1);
    chk(mod_out == 1'b0, "R7 one second half", int'(mod_out), 0);
    step(p/2 - 1);
    chk(mod_out == 1'b0, "R7 one end", int'(mod_out), 0);
    step(1);
    chk(mod_out == 1'b0, "R7 zero first half", int'(mod_out), 0);
    step(p/2);
    chk(mod_out == 1'b1, "R7 zero second half", int'(mod_out), 1);
    // restart in second half: phase must go back to first half
    do_restart(2'b10, 2, 1'b0);
    chk(mod_out == 1'b0, "R8 restart first chip", int'(mod_out), 0);
  endtask

  task automatic t_cancel;
    int n;
    do_restart(2'b01, 3, 1'b0);
    step(period(3) - 3);
    do_restart(2'b01, 3, 1'b0);
    edges_to_stb(period(3) + 4, n);
    chk(n == period(3), "R10 restart cancels", n, period(3));
  endtask

  task automatic t_ignore;
    int n;
    do_restart(2'b01, 1, 1'b1);
    mode = 2'b10; rate = '0;
    edges_to_stb(period(1) + 4, n);
    chk(n == period(1), "R11 rate ignored", n, period(1));
    data = 1'b1;
    step(period(1) / 2 + 1);
    chk(mod_out == 1'b1, "R11 format ignored", int'(mod_out), 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_period(0, "R9 fastest rate");
    t_period(5, "R4 first strobe");
    t_period(255, "R9 slowest rate");
    t_async();
    t_sync(2'b01, "R6 sync capture");
    t_sync(2'b11, "R2 code 11 as sync");
    t_manch();
    t_cancel();
    t_ignore();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule